// File: doc/BRIEF.md
# SPI Frame Sequencer

This block runs one framed SPI transaction at a time. A single 32-bit command word sets the frame: which chip select to drive, how many bytes to shift, how many leading bytes are write-only, and whether the frame is write-only or has a dual-lane read phase. Writing the command starts the frame. The sequencer drives the chosen chip select low for the whole frame. Bytes to send come from a transmit stream, received bytes go out on a receive stream, and a one-cycle done pulse follows the release of chip select.

SCK edges are paced by an external `sck_tick` enable. Each tick is one half period, so the clock divider stays outside the block. The bus runs in mode 0: SCK idles low, both directions are MSB first, input data is sampled on the rising edge, and output data changes after the falling edge. Both data streams use valid/ready. The block pops a transmit byte only at a byte boundary, and only when `tx_valid` and `tx_ready` are both high in a cycle. A received byte stays on `rx_data` with `rx_valid` high until `rx_ready` takes it. While a byte is held there, the next read-phase byte does not start.

Top module: `spi_frame_sequencer`

## Requirements
- R1: After reset, every `cs_n` line is high, `sck` is low, and `busy`, `done`, `rx_valid` and `tx_ready` are all low.
- R2: Bits 31:30 of the command select the chip select index. During the frame only that `cs_n` line is low, and it stays low from the first byte until the end of the hold time.
- R3: Bits 15:0 hold the frame length minus one. A single-lane frame of L bytes makes exactly 8·L rising SCK edges. The value 0 gives a one-byte frame.
- R4: SCK idles low. `sdo` carries each transmit byte MSB first and is stable at every rising edge. `sdi[0]` is sampled on rising edges, MSB first.
- R5: Bits 23:16 hold a skip count N. Bytes at indices 0 to N−1 are shifted, but their received data is discarded. Every later byte is pushed to the receive stream. If N is at least the frame length, nothing is pushed.
- R6: A read-phase byte (index ≥ N, with write-only clear) takes its transmit byte from the stream if one is valid, and otherwise sends 0x00 without waiting. `tx_ready` is never high outside a frame.
- R7: A byte outside the read phase waits for transmit data. While it waits, SCK stays low, the chip select stays low, and `busy` stays high.
- R8: Bit 28 with a nonzero skip count makes read-phase bytes dual-lane. Each byte takes 4 rising edges, and each edge gives the bit pair {`sdi[1]`,`sdi[0]`}, highest pair first. `sdo_en` is low during these bytes and no transmit byte is popped. With a zero skip count, bit 28 has no effect.
- R9: Bit 27 makes the whole frame write-only. No byte is pushed, and every byte waits for transmit data.
- R10: Chip select rises exactly CS_HOLD+1 clock cycles after the last falling SCK edge. `done` is high for exactly one cycle, in the first cycle that chip select is high.
- R11: A command written while `busy` is high is ignored. It does not change the running frame, and it does not start a frame later.
- R12: While `rx_valid` is high and `rx_ready` is low, `rx_valid` and `rx_data` hold their values, and no new read-phase byte starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_tick | input | 1 | Half-period enable for SCK |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 32 | Command word |
| tx_valid | input | 1 | Transmit byte available |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmit byte consumed this cycle |
| rx_valid | output | 1 | Received byte available |
| rx_data | output | 8 | Received byte |
| rx_ready | input | 1 | Consumer takes the received byte |
| sdi | input | 2 | Serial data in; lane 1 is used only in dual reads |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Output enable for sdo, low in the dual read phase |
| cs_n | output | NUM_CS | Active-low chip selects |
| busy | output | 1 | Frame accepted or in progress |
| done | output | 1 | One-cycle frame-complete pulse |

## Verification
The hardest states to reach from the ports are a frame stopped in the middle with chip select still low, and a frame blocked by a full receive output. The bench reaches the first by giving a skip-only frame fewer transmit bytes than it needs. It then writes a second command while the frame is frozen, checks that the frozen state has not changed, and supplies the remaining bytes. It reaches the second by holding `rx_ready` low across a two-byte read, so the second byte cannot start until the first is taken. A bit-level model of the slave returns a known pattern on both input lanes, so every received byte, in single-lane or dual-lane form, can be predicted from its rising-edge index alone.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 16;
  localparam int SKIP_W = 8;
  localparam int SEL_W  = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SHIFT,
    ST_HOLD,
    ST_DONE
  } seq_state_t;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic              dual;
    logic              wr_only;
    logic [SKIP_W-1:0] skip;
    logic [LEN_W-1:0]  last;
  } frame_cfg_t;

  // Field layout: [31:30] select, [28] dual read, [27] write-only,
  // [23:16] skip count, [15:0] length minus one.
  function automatic frame_cfg_t decode_cmd(input logic [31:0] w);
    frame_cfg_t c;
    c.sel     = w[31:30];
    c.wr_only = w[27];
    c.skip    = w[23:16];
    c.last    = w[15:0];
    c.dual    = w[28] & (|w[23:16]);
    return c;
  endfunction
endpackage

// File: rtl/sfs_cmd_latch.sv
module sfs_cmd_latch
  import sfs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_word,
  input  logic        idle,
  output frame_cfg_t  cfg,
  output logic        start
);
  logic accept;
  assign accept = cmd_wr && idle && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg   <= '0;
      start <= 1'b0;
    end else begin
      start <= accept;
      if (accept) cfg <= decode_cmd(cmd_word);
    end
  end
endmodule

// File: rtl/sfs_shifter.sv
module sfs_shifter
  import sfs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_tick,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  input  logic              load_dual,
  input  logic [1:0]        sdi,
  output logic              sck,
  output logic              sdo,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int STEP_W = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] tx_sh;
  logic [BYTE_W-1:0] rx_sh;
  logic [STEP_W-1:0] steps;
  logic              active;
  logic              dual_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh     <= '0;
      rx_sh     <= '0;
      steps     <= '0;
      active    <= 1'b0;
      dual_q    <= 1'b0;
      sck       <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (load) begin
        tx_sh  <= load_data;
        steps  <= load_dual ? STEP_W'(BYTE_W / 2) : STEP_W'(BYTE_W);
        active <= 1'b1;
        dual_q <= load_dual;
        sck    <= 1'b0;
      end else if (active && sck_tick) begin
        if (!sck) begin
          sck   <= 1'b1;
          steps <= steps - 1'b1;
          if (dual_q) rx_sh <= {rx_sh[BYTE_W-3:0], sdi[1], sdi[0]};
          else        rx_sh <= {rx_sh[BYTE_W-2:0], sdi[0]};
        end else begin
          sck <= 1'b0;
          if (steps == '0) begin
            active    <= 1'b0;
            byte_done <= 1'b1;
          end else begin
            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign sdo     = tx_sh[BYTE_W-1];
  assign rx_byte = rx_sh;
endmodule

// File: rtl/sfs_ctrl.sv
module sfs_ctrl
  import sfs_pkg::*;
#(
  parameter int CS_HOLD = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  frame_cfg_t        cfg,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  input  logic              rx_ready,
  output logic              shift_load,
  output logic [BYTE_W-1:0] shift_data,
  output logic              shift_dual,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              idle,
  output logic              frame_active,
  output logic              done,
  output logic              sdo_en
);
  localparam int HOLD_W = (CS_HOLD < 2) ? 1 : $clog2(CS_HOLD);

  seq_state_t        state;
  logic [LEN_W-1:0]  byte_idx;
  logic [HOLD_W-1:0] hold_cnt;
  logic              cur_read;
  logic              cur_dual;

  logic in_skip, read_ph, dual_ph, go;

  assign in_skip = byte_idx < LEN_W'(cfg.skip);
  assign read_ph = !in_skip && !cfg.wr_only;
  assign dual_ph = read_ph && cfg.dual;
  assign go      = read_ph ? !rx_valid : tx_valid;

  assign shift_load = (state == ST_LOAD) && go;
  assign tx_ready   = shift_load && tx_valid && !dual_ph;
  assign shift_data = tx_ready ? tx_data : '0;
  assign shift_dual = dual_ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      byte_idx <= '0;
      hold_cnt <= '0;
      cur_read <= 1'b0;
      cur_dual <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_LOAD;
            byte_idx <= '0;
          end
        end
        ST_LOAD: begin
          if (go) begin
            state    <= ST_SHIFT;
            cur_read <= read_ph;
            cur_dual <= dual_ph;
          end
        end
        ST_SHIFT: begin
          if (byte_done) begin
            if (cur_read) begin
              rx_valid <= 1'b1;
              rx_data  <= rx_byte;
            end
            cur_dual <= 1'b0;
            if (byte_idx == cfg.last) begin
              state    <= ST_HOLD;
              hold_cnt <= '0;
            end else begin
              byte_idx <= byte_idx + 1'b1;
              state    <= ST_LOAD;
            end
          end
        end
        ST_HOLD: begin
          if (hold_cnt == HOLD_W'(CS_HOLD - 1)) state <= ST_DONE;
          else hold_cnt <= hold_cnt + 1'b1;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign idle         = (state == ST_IDLE);
  assign done         = (state == ST_DONE);
  assign frame_active = (state == ST_LOAD) || (state == ST_SHIFT) || (state == ST_HOLD);
  assign sdo_en       = !((state == ST_SHIFT) && cur_dual);
endmodule

// File: rtl/spi_frame_sequencer.sv
module spi_frame_sequencer
  import sfs_pkg::*;
#(
  parameter int NUM_CS  = 4,
  parameter int CS_HOLD = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_tick,
  input  logic              cmd_wr,
  input  logic [31:0]       cmd_word,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  input  logic              rx_ready,
  input  logic [1:0]        sdi,
  output logic              sck,
  output logic              sdo,
  output logic              sdo_en,
  output logic [NUM_CS-1:0] cs_n,
  output logic              busy,
  output logic              done
);
  frame_cfg_t        cfg;
  logic              start, idle, frame_active;
  logic              shift_load, shift_dual, byte_done;
  logic [BYTE_W-1:0] shift_data, rx_byte;

  sfs_cmd_latch u_latch (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .idle(idle), .cfg(cfg), .start(start)
  );

  sfs_ctrl #(.CS_HOLD(CS_HOLD)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg(cfg),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .shift_load(shift_load), .shift_data(shift_data), .shift_dual(shift_dual),
    .byte_done(byte_done), .rx_byte(rx_byte), .idle(idle),
    .frame_active(frame_active), .done(done), .sdo_en(sdo_en)
  );

  sfs_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .sck_tick(sck_tick), .load(shift_load),
    .load_data(shift_data), .load_dual(shift_dual), .sdi(sdi),
    .sck(sck), .sdo(sdo), .byte_done(byte_done), .rx_byte(rx_byte)
  );

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n[i] = !(frame_active && (32'(cfg.sel) == i));
  end

  assign busy = !idle || start;
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic [7:0]        rx_data,
  input logic              rx_ready,
  input logic              sck,
  input logic              sdo_en,
  input logic [NUM_CS-1:0] cs_n,
  input logic              done
);
  assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  assert_sck_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> !sck);

  assert_no_pop_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> !tx_ready);

  assert_dual_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_en |-> !(&cs_n));

  assert_done_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (&cs_n));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_cs_steady_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&cs_n) && !$past(&cs_n)) |-> $stable(cs_n));

  assert_rx_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
endmodule

bind spi_frame_sequencer sfs_checker #(.NUM_CS(NUM_CS)) u_sfs_checker (
  .clk(clk), .rst_n(rst_n), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .rx_data(rx_data), .rx_ready(rx_ready), .sck(sck), .sdo_en(sdo_en),
  .cs_n(cs_n), .done(done)
);

// File: tb/spi_frame_sequencer_bench.sv
module spi_frame_sequencer_bench;
  localparam int NUM_CS  = 4;
  localparam int CS_HOLD = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n, sck_tick, cmd_wr, rx_ready;
  logic [31:0]       cmd_word;
  logic              tx_valid, tx_ready, rx_valid, sck, sdo, sdo_en, busy, done;
  logic [7:0]        tx_data, rx_data;
  logic [1:0]        sdi;
  logic [NUM_CS-1:0] cs_n;

  spi_frame_sequencer #(.NUM_CS(NUM_CS), .CS_HOLD(CS_HOLD)) u_spi_frame_sequencer (
    .clk(clk), .rst_n(rst_n), .sck_tick(sck_tick), .cmd_wr(cmd_wr),
    .cmd_word(cmd_word), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .sdi(sdi), .sck(sck), .sdo(sdo), .sdo_en(sdo_en),
    .cs_n(cs_n), .busy(busy), .done(done)
  );

  // Transmit source model.
  logic [7:0] txq [0:255];
  logic [7:0] wr_ptr = 8'd0;
  logic [7:0] rd_ptr = 8'd0;
  assign tx_valid = (rd_ptr != wr_ptr);
  assign tx_data  = txq[rd_ptr];
  always @(posedge clk) if (tx_valid && tx_ready) rd_ptr <= rd_ptr + 8'd1;

  // Receive sink model.
  logic [7:0] rxq [0:255];
  logic [7:0] rx_cnt = 8'd0;
  always @(posedge clk) if (rx_valid && rx_ready) begin
    rxq[rx_cnt] <= rx_data;
    rx_cnt      <= rx_cnt + 8'd1;
  end

  function automatic logic pat0(int r); return 1'(((r * 37 + 11) >> 2) & 1); endfunction
  function automatic logic pat1(int r); return 1'(((r * 23 + 5) >> 1) & 1); endfunction

  // Bus monitor and slave model, sampled on falling clk edges.
  int         cyc = 0, rises = 0, fall_cyc = 0, rise_cyc = 0, done_cyc = 0, done_cnt = 0;
  logic       mbit [0:511];
  logic       men  [0:511];
  logic [NUM_CS-1:0] cs_seen = '0;
  logic       prev_sck = 1'b0, prev_idle = 1'b1;

  always @(negedge clk) begin
    cyc      = cyc + 1;
    sck_tick = ~sck_tick;
    if (prev_idle && !(&cs_n)) begin
      rises    = 0;
      cs_seen  = '0;
      done_cnt = 0;
    end
    cs_seen = cs_seen | ~cs_n;
    if (!prev_sck && sck) begin
      mbit[rises] = sdo;
      men[rises]  = sdo_en;
      rises = rises + 1;
    end
    if (prev_sck && !sck) fall_cyc = cyc;
    if (!prev_idle && (&cs_n)) rise_cyc = cyc;
    if (done) begin
      done_cnt = done_cnt + 1;
      done_cyc = cyc;
    end
    sdi       = {pat1(rises), pat0(rises)};
    prev_sck  = sck;
    prev_idle = &cs_n;
  end

  int checks = 0, fails = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_single(int j);
    logic [7:0] v;
    for (int k = 0; k < 8; k++) v[7-k] = pat0(8 * j + k);
    return v;
  endfunction

  function automatic logic [7:0] exp_dual(int base);
    logic [7:0] v;
    for (int k = 0; k < 4; k++) begin
      v[7-2*k] = pat1(base + k);
      v[6-2*k] = pat0(base + k);
    end
    return v;
  endfunction

  function automatic logic [7:0] mosi_byte(int j);
    logic [7:0] v;
    for (int k = 0; k < 8; k++) v[7-k] = mbit[8 * j + k];
    return v;
  endfunction

  task automatic push(logic [7:0] d);
    txq[wr_ptr] = d;
    wr_ptr = wr_ptr + 8'd1;
  endtask

  task automatic send_cmd(logic [1:0] sel, bit dual, bit wo, logic [7:0] skip, logic [15:0] last);
    @(negedge clk);
    cmd_word = {sel, 1'b0, dual, wo, 3'b000, skip, last};
    cmd_wr   = 1'b1;
    @(negedge clk);
    cmd_wr   = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(&cs_n, "R1", "cs_n", cs_n, 4'hF);
    chk(!sck && !busy && !done, "R1", "sck/busy/done", {sck, busy, done}, 0);
    chk(!rx_valid && !tx_ready, "R1", "rx_valid/tx_ready", {rx_valid, tx_ready}, 0);
  endtask

  task automatic t_basic();
    logic [7:0] r0 = rx_cnt;
    push(8'hA1); push(8'hB2); push(8'hC3);
    send_cmd(2'd1, 0, 0, 8'd0, 16'd2);
    wait_done();
    chk(cs_seen == 4'b0010, "R2", "chip select used", cs_seen, 4'b0010);
    chk(rises == 24, "R3", "rising edges", rises, 24);
    chk(mosi_byte(0) == 8'hA1 && mosi_byte(2) == 8'hC3, "R4", "sdo bytes",
        {mosi_byte(0), mosi_byte(2)}, 16'hA1C3);
    chk(rx_cnt - r0 == 3, "R5", "pushed count", rx_cnt - r0, 3);
    for (int j = 0; j < 3; j++)
      chk(rxq[r0 + 8'(j)] == exp_single(j), "R4", "rx byte", rxq[r0 + 8'(j)], exp_single(j));
    chk(rise_cyc - fall_cyc == CS_HOLD + 1, "R10", "hold cycles", rise_cyc - fall_cyc, CS_HOLD + 1);
    chk(done_cnt == 1 && done_cyc == rise_cyc, "R10", "done pulse", done_cnt, 1);
  endtask

  task automatic t_skip();
    logic [7:0] r0 = rx_cnt;
    for (int j = 0; j < 5; j++) push(8'h10 + 8'(j));
    send_cmd(2'd0, 0, 0, 8'd2, 16'd4);
    wait_done();
    chk(rx_cnt - r0 == 3, "R5", "pushed after skip", rx_cnt - r0, 3);
    chk(rxq[r0] == exp_single(2), "R5", "first kept byte", rxq[r0], exp_single(2));
    chk(rxq[r0 + 8'd2] == exp_single(4), "R5", "last kept byte", rxq[r0 + 8'd2], exp_single(4));
    chk(mosi_byte(3) == 8'h13, "R6", "read phase uses queued byte", mosi_byte(3), 8'h13);
  endtask

  task automatic t_zero_fill();
    logic [7:0] p0 = rd_ptr;
    push(8'h5A);
    send_cmd(2'd2, 0, 0, 8'd1, 16'd3);
    wait_done();
    chk(rises == 32, "R3", "rising edges", rises, 32);
    chk(mosi_byte(0) == 8'h5A, "R6", "skip byte", mosi_byte(0), 8'h5A);
    chk(mosi_byte(1) == 8'h00 && mosi_byte(3) == 8'h00, "R6", "zero fill",
        {mosi_byte(1), mosi_byte(3)}, 0);
    chk(rd_ptr - p0 == 1, "R6", "pops", rd_ptr - p0, 1);
  endtask

  task automatic t_one_byte();
    push(8'h3C);
    send_cmd(2'd2, 0, 0, 8'd0, 16'd0);
    wait_done();
    chk(rises == 8, "R3", "one-byte frame edges", rises, 8);
  endtask

  task automatic t_dual();
    logic [7:0] r0 = rx_cnt;
    bit en_ok = 1;
    push(8'h9F);
    send_cmd(2'd0, 1, 0, 8'd1, 16'd2);
    wait_done();
    chk(rises == 16, "R8", "dual edges", rises, 16);
    for (int r = 0; r < 16; r++) if (men[r] != (r < 8)) en_ok = 0;
    chk(en_ok, "R8", "sdo_en pattern", en_ok, 1);
    chk(rxq[r0] == exp_dual(8), "R8", "dual byte 0", rxq[r0], exp_dual(8));
    chk(rxq[r0 + 8'd1] == exp_dual(12), "R8", "dual byte 1", rxq[r0 + 8'd1], exp_dual(12));
  endtask

  task automatic t_dual_noskip();
    logic [7:0] r0 = rx_cnt;
    send_cmd(2'd0, 1, 0, 8'd0, 16'd1);
    wait_done();
    chk(rises == 16, "R8", "dual without skip edges", rises, 16);
    chk(rxq[r0 + 8'd1] == exp_single(1), "R8", "single-lane byte", rxq[r0 + 8'd1], exp_single(1));
  endtask

  task automatic t_write_only();
    logic [7:0] r0 = rx_cnt;
    push(8'h01); push(8'h02); push(8'h03);
    send_cmd(2'd3, 0, 1, 8'd0, 16'd2);
    wait_done();
    chk(rx_cnt == r0, "R9", "no pushes", rx_cnt - r0, 0);
    chk(mosi_byte(2) == 8'h03, "R9", "last byte out", mosi_byte(2), 8'h03);
  endtask

  task automatic t_stall_and_ignore();
    logic [7:0] r0 = rx_cnt;
    push(8'hE1);
    send_cmd(2'd3, 0, 0, 8'd3, 16'd2);
    repeat (200) @(negedge clk);
    chk(rises == 8 && !sck, "R7", "stalled edges", rises, 8);
    chk(cs_n == 4'b0111 && busy, "R7", "cs held in stall", cs_n, 4'b0111);
    send_cmd(2'd0, 0, 0, 8'd0, 16'd0);
    repeat (20) @(negedge clk);
    chk(cs_n == 4'b0111 && rises == 8, "R11", "frame unchanged", cs_n, 4'b0111);
    push(8'hE2); push(8'hE3);
    wait_done();
    chk(rises == 24 && mosi_byte(2) == 8'hE3, "R7", "resumed frame", rises, 24);
    chk(rx_cnt == r0, "R5", "skip covers frame", rx_cnt - r0, 0);
    repeat (50) @(negedge clk);
    chk(&cs_n && !busy, "R11", "no late frame", {cs_n, busy}, 5'b11110);
  endtask

  task automatic t_backpressure();
    logic [7:0] r0 = rx_cnt;
    rx_ready = 1'b0;
    send_cmd(2'd1, 0, 0, 8'd0, 16'd1);
    repeat (150) @(negedge clk);
    chk(rises == 8, "R12", "second byte held back", rises, 8);
    chk(rx_valid && rx_data == exp_single(0), "R12", "held rx byte", rx_data, exp_single(0));
    rx_ready = 1'b1;
    wait_done();
    chk(rx_cnt - r0 == 2 && rxq[r0 + 8'd1] == exp_single(1), "R12", "after release",
        rxq[r0 + 8'd1], exp_single(1));
  endtask

  initial begin
    bit wd = 0;
    rst_n = 1'b0; sck_tick = 1'b0; cmd_wr = 1'b0; cmd_word = '0; rx_ready = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      begin
        t_reset();
        t_basic();
        t_skip();
        t_zero_fill();
        t_one_byte();
        t_dual();
        t_dual_noskip();
        t_write_only();
        t_stall_and_ignore();
        t_backpressure();
      end
      begin
        repeat (100000) @(posedge clk);
        wd = 1;
      end
    join_any
    disable fork;
    if (wd) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule